// File: doc/BRIEF.md
# Tagged Input Reorder Buffer

This block stages input data between a host processor and a DSP datapath. The host loads words ahead of need, in plain sequential bursts, and labels each word with a stream tag. The DSP side then asks for data by tag, in whatever order its algorithm wants. Several interleaved input streams can therefore share one store and be pulled apart at the consumer.

The store holds a fixed number of 32-bit entries. Each entry can be taken whole, or it can be taken as two 16-bit halves, so one store also serves as twice as many half-width slots. Each half has its own valid bit. An entry returns to the free pool only once both of its halves are gone. When the consumer asks for a tag that is not present, the block raises a stall and returns nothing. The consumer simply waits, and the host is never notified. When every entry is occupied, host writes are refused.

Top module: `tagged_reorder_buffer`

## Requirements
- R1: After reset every entry is empty: `wrReady` is 1, and any read request stalls.
- R2: A write with `wrValid` high while `wrReady` is high stores `wrData` and `wrTag` into a free entry, and marks both halves valid. The data can be read from the next cycle onward.
- R3: `wrReady` is 0 while every entry holds at least one valid half. A write offered then is ignored and is never returned by any later read.
- R4: A wide read (`rdWide`=1) returns the whole 32-bit word of a matching entry whose two halves are both valid, with bits unchanged from the write. It frees that entry.
- R5: A half read (`rdWide`=0) picks a matching entry with at least one valid half. It returns the low half (write bits 15:0) if that half is still valid, and otherwise the high half (write bits 31:16). The value appears on `rdData[15:0]`, with bits 31:16 driven to zero. The read frees only that half.
- R6: Consumption follows the requested tag, not the arrival order. A later-written tag can be read while older entries of other tags remain.
- R7: When several valid entries carry the requested tag, the entry written earliest is chosen.
- R8: A read request that finds no usable entry sets `rdStall`=1, `rdValid`=0 and `rdData`=0, and consumes nothing. A wide request on an entry that has only one half left counts as no usable entry.
- R9: A write and a consuming read in the same cycle both take effect. An entry freed by a read while the buffer is full lets `wrReady` rise on the next cycle, and that entry can then be written.
- R10: With `rdReq` low, `rdValid` and `rdStall` are 0 and `rdData` is 0.
- R11: A word written in a given cycle is not visible to a read in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Host offers a word |
| wrTag | input | TAG_W | Stream tag of the offered word |
| wrData | input | DATA_W | Offered word |
| wrReady | output | 1 | A free entry exists; the write is taken |
| rdReq | input | 1 | Consumer requests an item |
| rdWide | input | 1 | 1 = whole word, 0 = one half |
| rdTag | input | TAG_W | Requested stream tag |
| rdValid | output | 1 | Request served this cycle |
| rdStall | output | 1 | Request cannot be served |
| rdData | output | DATA_W | Returned word or zero-extended half |

## Verification
A host write and a consuming read can fall in the same clock cycle. Two situations matter most: the buffer being full, and the write carrying the very tag being requested.

The bench fills all entries and then offers a write together with a wide read. The write must be refused in that cycle, and `wrReady` must rise one cycle later. A following write paired with another read must land in the freed entry and read back intact.

Separately, a write of the requested tag issued alongside the read must leave that read stalled. The new word must be returned only in a later cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Slot index width carried in the strobe struct; supports up to 256 entries.
  localparam int SLOT_W = 8;

  typedef struct packed {
    logic              wrEn;
    logic [SLOT_W-1:0] wrSlot;
    logic              rdEn;
    logic [SLOT_W-1:0] rdSlot;
    logic              rdWide;
    logic              rdHi;
  } rob_strobe_t;
endpackage

// File: rtl/rob_age.sv
module rob_age #(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ENTRIES-1:0] wrOneHot,
  input  logic [ENTRIES-1:0] cand,
  output logic [ENTRIES-1:0] pick
);
  // olderRow[j][i] = 1 when entry j was written before entry i
  logic [ENTRIES-1:0] olderRow [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < ENTRIES; j++) olderRow[j] <= '0;
    end else if (wrEn) begin
      for (int j = 0; j < ENTRIES; j++) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (i != j) begin
            if (wrOneHot[j])      olderRow[j][i] <= 1'b0;
            else if (wrOneHot[i]) olderRow[j][i] <= 1'b1;
          end
        end
      end
    end
  end

  // A candidate wins when no other candidate is older than it.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      pick[i] = cand[i];
      for (int j = 0; j < ENTRIES; j++) begin
        if (cand[j] && olderRow[j][i]) pick[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic               rdReq,
  input  logic               rdWide,
  input  logic [ENTRIES-1:0] tagMatch,
  output logic               wrReady,
  output logic               rdValid,
  output logic               rdStall,
  output rob_strobe_t        strobe
);
  logic [ENTRIES-1:0] loValid, hiValid;
  logic [ENTRIES-1:0] occupied, wrOneHot, cand, pick;
  logic [SLOT_W-1:0]  wrSlotIdx, rdSlotIdx;
  logic               wrEn, rdEn, hit;

  assign occupied = loValid | hiValid;
  assign wrReady  = ~&occupied;
  assign wrEn     = wrValid & wrReady;

  // Lowest-numbered free entry receives the next write.
  always_comb begin
    wrOneHot  = '0;
    wrSlotIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occupied[i]) begin
        wrOneHot  = '0;
        wrOneHot[i] = 1'b1;
        wrSlotIdx = SLOT_W'(i);
      end
    end
  end

  assign cand = rdWide ? (tagMatch & loValid & hiValid)
                       : (tagMatch & occupied);
  assign hit     = |cand;
  assign rdEn    = rdReq & hit;
  assign rdValid = rdEn;
  assign rdStall = rdReq & ~hit;

  rob_age #(.ENTRIES(ENTRIES)) uAge (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrOneHot (wrOneHot),
    .cand     (cand),
    .pick     (pick)
  );

  always_comb begin
    rdSlotIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (pick[i]) rdSlotIdx = SLOT_W'(i);
    end
  end

  always_comb begin
    strobe.wrEn   = wrEn;
    strobe.wrSlot = wrSlotIdx;
    strobe.rdEn   = rdEn;
    strobe.rdSlot = rdSlotIdx;
    strobe.rdWide = rdWide;
    strobe.rdHi   = ~rdWide & |(pick & ~loValid);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loValid <= '0;
      hiValid <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wrEn && wrOneHot[i]) begin
          loValid[i] <= 1'b1;
          hiValid[i] <= 1'b1;
        end else if (rdEn && pick[i]) begin
          if (rdWide) begin
            loValid[i] <= 1'b0;
            hiValid[i] <= 1'b0;
          end else if (loValid[i]) begin
            loValid[i] <= 1'b0;
          end else begin
            hiValid[i] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rob_datapath.sv
module rob_datapath
  import rob_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  rob_strobe_t        strobe,
  input  logic [TAG_W-1:0]   wrTag,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [TAG_W-1:0]   rdTag,
  output logic [ENTRIES-1:0] tagMatch,
  output logic [DATA_W-1:0]  rdData
);
  localparam int HALF_W = DATA_W / 2;

  logic [TAG_W-1:0]  tagMem  [ENTRIES];
  logic [DATA_W-1:0] dataMem [ENTRIES];
  logic [DATA_W-1:0] selWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tagMem[e]  <= '0;
        dataMem[e] <= '0;
      end
    end else if (strobe.wrEn) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (strobe.wrSlot == SLOT_W'(e)) begin
          tagMem[e]  <= wrTag;
          dataMem[e] <= wrData;
        end
      end
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : gMatch
    assign tagMatch[e] = (tagMem[e] == rdTag);
  end

  always_comb begin
    selWord = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (strobe.rdSlot == SLOT_W'(e)) selWord = dataMem[e];
    end
  end

  always_comb begin
    if (!strobe.rdEn)       rdData = '0;
    else if (strobe.rdWide) rdData = selWord;
    else if (strobe.rdHi)   rdData = {{(DATA_W-HALF_W){1'b0}}, selWord[DATA_W-1:HALF_W]};
    else                    rdData = {{(DATA_W-HALF_W){1'b0}}, selWord[HALF_W-1:0]};
  end
endmodule

// File: rtl/tagged_reorder_buffer.sv
module tagged_reorder_buffer
  import rob_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  input  logic              rdReq,
  input  logic              rdWide,
  input  logic [TAG_W-1:0]  rdTag,
  output logic              rdValid,
  output logic              rdStall,
  output logic [DATA_W-1:0] rdData
);
  rob_strobe_t        strobe;
  logic [ENTRIES-1:0] tagMatch;

  rob_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (wrValid),
    .rdReq    (rdReq),
    .rdWide   (rdWide),
    .tagMatch (tagMatch),
    .wrReady  (wrReady),
    .rdValid  (rdValid),
    .rdStall  (rdStall),
    .strobe   (strobe)
  );

  rob_datapath #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .TAG_W(TAG_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrTag    (wrTag),
    .wrData   (wrData),
    .rdTag    (rdTag),
    .tagMatch (tagMatch),
    .rdData   (rdData)
  );
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrReady,
  input logic              rdReq,
  input logic              rdWide,
  input logic              rdValid,
  input logic              rdStall,
  input logic [DATA_W-1:0] rdData
);
  AST_STALL_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rdStall |-> (!rdValid && rdData == '0));  // R8
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdValid != rdStall));  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |-> (!rdValid && !rdStall && rdData == '0));  // R10
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdWide) |-> (rdData[DATA_W-1:DATA_W/2] == '0));  // R5
  AST_WIDE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdWide && !wrReady) |=> wrReady);  // R9
  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (!wrReady && !rdValid) |=> !wrReady);  // R3
endmodule

bind tagged_reorder_buffer rob_checker #(.DATA_W(DATA_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wrReady (wrReady),
  .rdReq   (rdReq),
  .rdWide  (rdWide),
  .rdValid (rdValid),
  .rdStall (rdStall),
  .rdData  (rdData)
);

// File: tb/tb_tagged_reorder_buffer.sv
module tb_tagged_reorder_buffer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [3:0]  wrTag = '0;
  logic [31:0] wrData = '0;
  logic        wrReady;
  logic        rdReq = 1'b0;
  logic        rdWide = 1'b0;
  logic [3:0]  rdTag = '0;
  logic        rdValid;
  logic        rdStall;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tagged_reorder_buffer dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrTag(wrTag), .wrData(wrData),
    .wrReady(wrReady), .rdReq(rdReq), .rdWide(rdWide), .rdTag(rdTag),
    .rdValid(rdValid), .rdStall(rdStall), .rdData(rdData)
  );

  typedef struct packed {
    logic        wv;
    logic [3:0]  wt;
    logic [31:0] wd;
    logic        rq;
    logic        rw;
    logic [3:0]  rt;
    logic        eReady;
    logic        eValid;
    logic        eStall;
    logic [31:0] eData;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'd1, 32'h1111AAAA, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 32'h0},          // R2 write tag1
    '{1'b1, 4'd2, 32'h2222BBBB, 1'b1, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0, 32'h1111AAAA},   // R4 wide read + write
    '{1'b1, 4'd1, 32'h3333CCCC, 1'b1, 1'b1, 4'd1, 1'b1, 1'b0, 1'b1, 32'h0},          // R11 same-cycle write invisible
    '{1'b1, 4'd1, 32'h4444DDDD, 1'b1, 1'b0, 4'd1, 1'b1, 1'b1, 1'b0, 32'h0000CCCC},   // R5 R7 oldest, low half
    '{1'b0, 4'd0, 32'h0,        1'b1, 1'b0, 4'd1, 1'b1, 1'b1, 1'b0, 32'h00003333},   // R5 high half
    '{1'b0, 4'd0, 32'h0,        1'b1, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0, 32'h4444DDDD},   // R7 next tag1
    '{1'b0, 4'd0, 32'h0,        1'b1, 1'b1, 4'd2, 1'b1, 1'b1, 1'b0, 32'h2222BBBB},   // R6 older tag2 last
    '{1'b0, 4'd0, 32'h0,        1'b1, 1'b0, 4'd2, 1'b1, 1'b0, 1'b1, 32'h0},          // R8 none left
    '{1'b0, 4'd0, 32'h0,        1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 32'h0},          // R10 idle
    '{1'b1, 4'd3, 32'h5555EEEE, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 32'h0},          // R2 write tag3
    '{1'b0, 4'd0, 32'h0,        1'b1, 1'b0, 4'd3, 1'b1, 1'b1, 1'b0, 32'h0000EEEE},   // R5 low half
    '{1'b0, 4'd0, 32'h0,        1'b1, 1'b1, 4'd3, 1'b1, 1'b0, 1'b1, 32'h0},          // R8 wide on half entry
    '{1'b0, 4'd0, 32'h0,        1'b1, 1'b0, 4'd3, 1'b1, 1'b1, 1'b0, 32'h00005555},   // R5 high half
    '{1'b0, 4'd0, 32'h0,        1'b1, 1'b0, 4'd3, 1'b1, 1'b0, 1'b1, 32'h0}           // R8 entry drained
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic wv, input logic [3:0] wt, input logic [31:0] wd,
                       input logic rq, input logic rw, input logic [3:0] rt);
    @(negedge clk);
    wrValid = wv; wrTag = wt; wrData = wd;
    rdReq = rq; rdWide = rw; rdTag = rt;
    #5;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrValid = 1'b0; rdReq = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [31:0] fillWord(input int i);
    return {16'(16'hC0D0 + i), 16'(16'hF000 + i)};
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    drive(1'b0, 4'd0, 32'h0, 1'b1, 1'b1, 4'd0);
    chk("R1", "wrReady after reset", {31'b0, wrReady}, 32'd1);
    chk("R1", "rdStall after reset", {31'b0, rdStall}, 32'd1);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      drive(VECS[v].wv, VECS[v].wt, VECS[v].wd, VECS[v].rq, VECS[v].rw, VECS[v].rt);
      chk("R2", $sformatf("vec %0d wrReady", v), {31'b0, wrReady}, {31'b0, VECS[v].eReady});
      chk("R8", $sformatf("vec %0d rdValid", v), {31'b0, rdValid}, {31'b0, VECS[v].eValid});
      chk("R8", $sformatf("vec %0d rdStall", v), {31'b0, rdStall}, {31'b0, VECS[v].eStall});
      chk("R4", $sformatf("vec %0d rdData", v), rdData, VECS[v].eData);
    end

    // Fill, full refusal, same-cycle write/read and reuse
    doReset();
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 4'(i), fillWord(i), 1'b0, 1'b0, 4'd0);
      chk("R2", $sformatf("wrReady fill %0d", i), {31'b0, wrReady}, 32'd1);
    end
    drive(1'b1, 4'd9, 32'hDEAD0009, 1'b0, 1'b0, 4'd0);
    chk("R3", "wrReady when full", {31'b0, wrReady}, 32'd0);
    drive(1'b1, 4'd9, 32'hBEEF0009, 1'b1, 1'b1, 4'd3);
    chk("R3", "wrReady full during read", {31'b0, wrReady}, 32'd0);
    chk("R6", "rdData tag3 out of order", rdData, fillWord(3));
    drive(1'b0, 4'd0, 32'h0, 1'b1, 1'b1, 4'd9);
    chk("R3", "refused write not stored", {31'b0, rdStall}, 32'd1);
    chk("R9", "wrReady after freeing read", {31'b0, wrReady}, 32'd1);
    drive(1'b1, 4'd9, 32'h0BADF00D, 1'b1, 1'b1, 4'd5);
    chk("R9", "same-cycle read data", rdData, fillWord(5));
    chk("R9", "same-cycle write ready", {31'b0, wrReady}, 32'd1);
    drive(1'b0, 4'd0, 32'h0, 1'b1, 1'b1, 4'd9);
    chk("R9", "reused entry data", rdData, 32'h0BADF00D);
    drive(1'b1, 4'd10, 32'h0000000A, 1'b0, 1'b0, 4'd0);
    drive(1'b1, 4'd11, 32'h0000000B, 1'b0, 1'b0, 4'd0);
    chk("R2", "last free entry written", {31'b0, wrReady}, 32'd1);
    drive(1'b0, 4'd0, 32'h0, 1'b1, 1'b0, 4'd0);
    chk("R3", "wrReady full again", {31'b0, wrReady}, 32'd0);
    chk("R5", "half read low", rdData, {16'h0, 16'hF000});
    drive(1'b0, 4'd0, 32'h0, 1'b1, 1'b0, 4'd0);
    chk("R5", "one half keeps entry", {31'b0, wrReady}, 32'd0);
    chk("R5", "half read high", rdData, {16'h0, 16'hC0D0});
    drive(1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 4'd0);
    chk("R5", "both halves free entry", {31'b0, wrReady}, 32'd1);
    chk("R10", "idle data zero", rdData, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule